// File: doc/BRIEF.md
# Variable Page Size Translation Lookaside Buffer

This block translates a 32-bit virtual address into a physical address using a small, fully associative, unified table of translation entries. Each entry carries its own page size. A 3-bit code picks one of eight sizes, growing by a factor of four from 1 KB to 16 MB. Software loads an entry through an indexed write port. The port supplies a tag word (virtual page bits, size code, valid flag), a frame word (physical page bits) and an 8-bit translation tag that must equal the current process tag before the entry can match.

A lookup request supplies the address, whether the access is an instruction fetch or a data access, and the current process tag. Two machine-state inputs enable translation separately for fetches and for data. When translation is off for the requested kind of access, the address passes through unchanged and is flagged uncached. Otherwise the lowest-numbered matching entry supplies the physical page. When no entry matches, a miss is reported. The result comes out one clock after the request.

Top module: `vpsTlb`

## Requirements
- R1: After reset rspValid, rspHit, rspMiss and rspUncached are 0, and every entry is invalid, so a translated lookup misses.
- R2: A write with wrEn high stores wrHi, wrLo and wrTid into entry wrIdx. Tag word layout: bits [31:10] virtual page bits, bits [9:7] size code, bit 6 valid. A lookup in the same cycle as a write still sees the old entry contents. The new contents apply from the next cycle.
- R3: Size code c selects the compare mask 0xFFFFFFFF shifted left by 10+2c bits: code 0 gives 1 KB (0xFFFFFC00) and code 7 gives 16 MB (0xFF000000).
- R4: An entry is a candidate only when its valid bit is 1 and its translation tag equals curPid.
- R5: A candidate matches when (lkAddr AND mask) equals (tag word AND mask). The physical address is then (frame word AND mask) OR (lkAddr AND NOT mask), with rspHit=1, rspMiss=0 and rspUncached=0.
- R6: When several candidates match, the one with the lowest index supplies the result.
- R7: When lkIsFetch=1 and xlatFetchEn=0, or lkIsFetch=0 and xlatDataEn=0, the response has rspHit=1, rspUncached=1 and rspPaddr equal to lkAddr, whatever the table holds. The enable for the other access kind has no effect.
- R8: A translated lookup with no matching candidate gives rspMiss=1, rspHit=0, rspUncached=0 and rspPaddr=0.
- R9: rspValid is 1 exactly one cycle after lkValid was 1. When rspValid is 0, rspHit, rspMiss and rspUncached are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | IDX_W | Entry index to write |
| wrHi | input | 32 | Tag word: page bits, size code, valid |
| wrLo | input | 32 | Frame word: physical page bits |
| wrTid | input | 8 | Translation tag of the entry |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 32 | Virtual address to translate |
| lkIsFetch | input | 1 | 1 for instruction fetch, 0 for data access |
| curPid | input | 8 | Current process tag |
| xlatFetchEn | input | 1 | Translation enable for fetches |
| xlatDataEn | input | 1 | Translation enable for data accesses |
| rspValid | output | 1 | Response valid, one cycle after request |
| rspHit | output | 1 | Address translated or passed through |
| rspMiss | output | 1 | No matching entry |
| rspPaddr | output | 32 | Physical address |
| rspUncached | output | 1 | Pass-through access, marked uncached |

## Verification
The bench sweeps all eight size codes with addresses just inside and just outside each page. A design with a wrong mask would either merge neighbouring pages or leak page bits into the offset. It places two matching entries at different indices and then invalidates the lower one. A reversed priority encoder would return the wrong frame. It writes an entry and looks it up in the same cycle. A design with write-through visibility would hit one cycle early. It also flips the fetch and data enables independently and mismatches the process tag. A design that crossed the enables or ignored the tag would translate when it should pass through, or hit when it should miss.

// File: rtl/vpsTlbPkg.sv
package vpsTlbPkg;
  localparam int ADDR_W   = 32;
  localparam int TID_W    = 8;
  localparam int SIZE_LSB = 7;
  localparam int SIZE_W   = 3;
  localparam int VALID_BIT = 6;
  localparam int MIN_SHIFT = 10;

  typedef struct packed {
    logic lookup;
    logic bypass;
  } tlbStrobe_t;

  function automatic logic [ADDR_W-1:0] sizeMask(input logic [SIZE_W-1:0] code);
    logic [4:0] sh;
    sh = 5'(MIN_SHIFT) + {1'b0, code, 1'b0};
    return {ADDR_W{1'b1}} << sh;
  endfunction
endpackage

// File: rtl/vpsTlbControl.sv
module vpsTlbControl
  import vpsTlbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lkValid,
  input  logic       lkIsFetch,
  input  logic       xlatFetchEn,
  input  logic       xlatDataEn,
  output tlbStrobe_t strobe,
  output logic       rspValid
);
  logic xlatOn;

  always_comb begin
    xlatOn = lkIsFetch ? xlatFetchEn : xlatDataEn;
    strobe.lookup = lkValid;
    strobe.bypass = lkValid && !xlatOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= lkValid;
  end

  // R9
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);
  // R9
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid);
endmodule

// File: rtl/vpsTlbDatapath.sv
module vpsTlbDatapath
  import vpsTlbPkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrHi,
  input  logic [ADDR_W-1:0] wrLo,
  input  logic [TID_W-1:0]  wrTid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [TID_W-1:0]  curPid,
  input  tlbStrobe_t        strobe,
  output logic              rspHit,
  output logic              rspMiss,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic              rspUncached
);
  logic [ADDR_W-1:0] entHi  [NUM_ENTRIES];
  logic [ADDR_W-1:0] entLo  [NUM_ENTRIES];
  logic [TID_W-1:0]  entTid [NUM_ENTRIES];
  logic [ADDR_W-1:0] entMask[NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] matchVec;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_ENTRIES; gi++) begin : gEntry
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          entHi[gi]  <= '0;
          entLo[gi]  <= '0;
          entTid[gi] <= '0;
        end else if (wrEn && wrIdx == IDX_W'(gi)) begin
          entHi[gi]  <= wrHi;
          entLo[gi]  <= wrLo;
          entTid[gi] <= wrTid;
        end
      end

      always_comb begin
        entMask[gi]  = sizeMask(entHi[gi][SIZE_LSB +: SIZE_W]);
        matchVec[gi] = entHi[gi][VALID_BIT] && (entTid[gi] == curPid) &&
                       ((lkAddr & entMask[gi]) == (entHi[gi] & entMask[gi]));
      end
    end
  endgenerate

  logic             anyMatch;
  logic [IDX_W-1:0] winIdx;

  always_comb begin
    anyMatch = 1'b0;
    winIdx   = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyMatch = 1'b1;
        winIdx   = IDX_W'(i);
      end
    end
  end

  logic [ADDR_W-1:0] winMask;
  logic [ADDR_W-1:0] xlatAddr;

  always_comb begin
    winMask  = entMask[winIdx];
    xlatAddr = (entLo[winIdx] & winMask) | (lkAddr & ~winMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspHit      <= 1'b0;
      rspMiss     <= 1'b0;
      rspPaddr    <= '0;
      rspUncached <= 1'b0;
    end else if (!strobe.lookup) begin
      rspHit      <= 1'b0;
      rspMiss     <= 1'b0;
      rspPaddr    <= '0;
      rspUncached <= 1'b0;
    end else if (strobe.bypass) begin
      rspHit      <= 1'b1;
      rspMiss     <= 1'b0;
      rspPaddr    <= lkAddr;
      rspUncached <= 1'b1;
    end else if (anyMatch) begin
      rspHit      <= 1'b1;
      rspMiss     <= 1'b0;
      rspPaddr    <= xlatAddr;
      rspUncached <= 1'b0;
    end else begin
      rspHit      <= 1'b0;
      rspMiss     <= 1'b1;
      rspPaddr    <= '0;
      rspUncached <= 1'b0;
    end
  end

  // R5
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rspHit && rspMiss));
  // R8
  miss_zero_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> (rspPaddr == '0 && !rspUncached));
  // R7
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookup && strobe.bypass) |=>
      (rspHit && rspUncached && rspPaddr == $past(lkAddr)));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lookup |=> (!rspHit && !rspMiss && !rspUncached));
endmodule

// File: rtl/vpsTlb.sv
module vpsTlb
  import vpsTlbPkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [31:0]       wrHi,
  input  logic [31:0]       wrLo,
  input  logic [7:0]        wrTid,
  input  logic              lkValid,
  input  logic [31:0]       lkAddr,
  input  logic              lkIsFetch,
  input  logic [7:0]        curPid,
  input  logic              xlatFetchEn,
  input  logic              xlatDataEn,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic [31:0]       rspPaddr,
  output logic              rspUncached
);
  tlbStrobe_t strobe;

  vpsTlbControl u_ctrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkIsFetch(lkIsFetch),
    .xlatFetchEn(xlatFetchEn), .xlatDataEn(xlatDataEn),
    .strobe(strobe), .rspValid(rspValid)
  );

  vpsTlbDatapath #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrHi(wrHi),
    .wrLo(wrLo), .wrTid(wrTid), .lkAddr(lkAddr), .curPid(curPid),
    .strobe(strobe), .rspHit(rspHit), .rspMiss(rspMiss),
    .rspPaddr(rspPaddr), .rspUncached(rspUncached)
  );
endmodule

// File: tb/vpsTlb_bench.sv
`timescale 1ns/1ps
module vpsTlb_bench;
  localparam int N = 64;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [IW-1:0] wrIdx = '0;
  logic [31:0] wrHi = '0, wrLo = '0;
  logic [7:0] wrTid = '0;
  logic lkValid = 1'b0;
  logic [31:0] lkAddr = '0;
  logic lkIsFetch = 1'b0;
  logic [7:0] curPid = '0;
  logic xlatFetchEn = 1'b1, xlatDataEn = 1'b1;
  logic rspValid, rspHit, rspMiss, rspUncached;
  logic [31:0] rspPaddr;

  always #4 clk = ~clk;

  vpsTlb u_vpsTlb (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrHi(wrHi),
    .wrLo(wrLo), .wrTid(wrTid), .lkValid(lkValid), .lkAddr(lkAddr),
    .lkIsFetch(lkIsFetch), .curPid(curPid), .xlatFetchEn(xlatFetchEn),
    .xlatDataEn(xlatDataEn), .rspValid(rspValid), .rspHit(rspHit),
    .rspMiss(rspMiss), .rspPaddr(rspPaddr), .rspUncached(rspUncached)
  );

  logic [31:0] mHi [N];
  logic [31:0] mLo [N];
  logic [7:0]  mTid[N];
  int compared = 0, mismatched = 0;
  bit done = 0;

  function automatic logic [31:0] maskOf(input logic [2:0] c);
    longint unsigned pageBytes;
    pageBytes = 64'd1024;
    for (int k = 0; k < c; k++) pageBytes = pageBytes * 4;
    return ~(32'(pageBytes - 1));
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // One clock: model predicts from current drive, then compare after the edge
  task automatic cyc(input string tag);
    logic eV, eH, eM, eU;
    logic [31:0] eP;
    logic xl;
    eV = lkValid; eH = 0; eM = 0; eU = 0; eP = '0;
    if (lkValid) begin
      xl = lkIsFetch ? xlatFetchEn : xlatDataEn;
      if (!xl) begin
        eH = 1; eU = 1; eP = lkAddr;
      end else begin
        bit found;
        found = 0;
        for (int i = 0; i < N; i++) begin
          logic [31:0] m;
          m = maskOf(mHi[i][9:7]);
          if (!found && mHi[i][6] && mTid[i] == curPid &&
              (lkAddr & m) == (mHi[i] & m)) begin
            found = 1; eH = 1; eP = (mLo[i] & m) | (lkAddr & ~m);
          end
        end
        if (!found) eM = 1;
      end
    end
    @(posedge clk);
    if (wrEn) begin
      mHi[wrIdx] = wrHi; mLo[wrIdx] = wrLo; mTid[wrIdx] = wrTid;
    end
    @(negedge clk);
    compared++;
    if (rspValid !== eV || rspHit !== eH || rspMiss !== eM ||
        rspUncached !== eU || rspPaddr !== eP) begin
      mismatched++;
      $display("FAIL %s: got v=%b h=%b m=%b u=%b pa=%h expected v=%b h=%b m=%b u=%b pa=%h",
               tag, rspValid, rspHit, rspMiss, rspUncached, rspPaddr,
               eV, eH, eM, eU, eP);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] hi, input logic [31:0] lo,
                    input logic [7:0] tid);
    wrEn = 1; wrIdx = IW'(idx); wrHi = hi; wrLo = lo; wrTid = tid;
  endtask

  task automatic lk(input logic [31:0] a, input logic f, input logic [7:0] pid);
    lkValid = 1; lkAddr = a; lkIsFetch = f; curPid = pid;
  endtask

  task automatic idle();
    wrEn = 0; lkValid = 0;
  endtask

  function automatic logic [31:0] mkHi(input logic [31:0] va, input logic [2:0] c,
                                       input logic v);
    return (va & 32'hFFFFFC00) | (32'(c) << 7) | (32'(v) << 6);
  endfunction

  initial begin
    #(8 * 200000);
    compared++; mismatched++;
    $display("FAIL watchdog: got running expected finished");
    finishRun();
  end

  initial begin
    for (int i = 0; i < N; i++) begin mHi[i] = '0; mLo[i] = '0; mTid[i] = '0; end
    @(negedge clk);
    // R1 outputs held quiet in reset
    compared++;
    if (rspValid !== 0 || rspHit !== 0 || rspMiss !== 0 || rspUncached !== 0) begin
      mismatched++;
      $display("FAIL R1: got v=%b h=%b m=%b u=%b expected all 0",
               rspValid, rspHit, rspMiss, rspUncached);
    end
    @(negedge clk); rstN = 1;
    // R1 empty table misses
    lk(32'h0000_0000, 0, 0); cyc("R1");
    lk(32'h1234_5678, 1, 0); cyc("R8");
    // R2 write and same-cycle lookup sees old
    wr(5, mkHi(32'h1234_5000, 3'd1, 1), 32'hABCD_E000, 8'd3);
    lk(32'h1234_5678, 0, 3); cyc("R2");
    idle(); lk(32'h1234_5678, 0, 3); cyc("R5");
    lk(32'h1234_5ABC, 1, 3); cyc("R5");
    // R4 tag mismatch and invalid
    lk(32'h1234_5678, 0, 4); cyc("R4");
    wr(5, mkHi(32'h1234_5000, 3'd1, 0), 32'hABCD_E000, 8'd3); lkValid = 0; cyc("R2");
    idle(); lk(32'h1234_5678, 0, 3); cyc("R4");
    // R3 size sweep
    for (int c = 0; c < 8; c++) begin
      logic [31:0] base, m;
      m = maskOf(3'(c));
      base = 32'h5A5A_5A5A & m;
      wr(10, mkHi(base, 3'(c), 1), 32'hC3C3_C3C3 & 32'hFFFFFC00, 8'd7);
      lkValid = 0; cyc("R3");
      idle();
      lk(base, 0, 7); cyc("R3");
      lk(base | ~m, 0, 7); cyc("R3");
      lk((base | ~m) + 1, 0, 7); cyc("R3");
      lk(base - 1, 1, 7); cyc("R3");
    end
    wr(10, 32'h0, 32'h0, 8'd0); lkValid = 0; cyc("R2"); idle();
    // R6 priority
    wr(7, mkHi(32'h8000_0000, 3'd7, 1), 32'h1100_0000, 8'd1); cyc("R6");
    wr(2, mkHi(32'h8040_0000, 3'd5, 1), 32'h2200_0000, 8'd1); cyc("R6");
    idle(); lk(32'h8041_2345, 0, 1); cyc("R6");
    lk(32'h8091_2345, 0, 1); cyc("R6");
    wr(2, 32'h0, 32'h0, 8'd1); lkValid = 0; cyc("R6");
    idle(); lk(32'h8041_2345, 0, 1); cyc("R6");
    // R7 bypass per access kind
    xlatFetchEn = 0; xlatDataEn = 1;
    lk(32'h8041_2345, 1, 1); cyc("R7");
    lk(32'h8041_2345, 0, 1); cyc("R7");
    lk(32'hDEAD_BEEF, 0, 1); cyc("R7");
    xlatFetchEn = 1; xlatDataEn = 0;
    lk(32'hDEAD_BEEF, 0, 9); cyc("R7");
    lk(32'h8041_2345, 1, 1); cyc("R7");
    lk(32'hDEAD_BEEF, 1, 1); cyc("R8");
    xlatDataEn = 1;
    // R9 gaps between requests
    idle(); cyc("R9"); cyc("R9");
    lk(32'h8000_0004, 0, 1); cyc("R9"); idle(); cyc("R9");
    // random stress
    for (int n = 0; n < 3000; n++) begin
      int idx;
      idle();
      if ($urandom_range(0, 2) == 0) begin
        logic [31:0] va;
        va = {$urandom_range(0, 3) == 0 ? 8'h80 : 8'($urandom_range(0, 3)), 24'($urandom)};
        wr($urandom_range(0, N - 1), mkHi(va, 3'($urandom_range(0, 7)),
           1'($urandom_range(0, 5) != 0)), $urandom, 8'($urandom_range(0, 3)));
      end
      if ($urandom_range(0, 3) != 0) begin
        idx = $urandom_range(0, N - 1);
        lk($urandom_range(0, 1) ? (mHi[idx] ^ 32'($urandom_range(0, 32'h3FFF))) : $urandom,
           1'($urandom_range(0, 1)), 8'($urandom_range(0, 3)));
      end
      xlatFetchEn = ($urandom_range(0, 7) != 0);
      xlatDataEn  = ($urandom_range(0, 7) != 0);
      cyc("R5");
    end
    idle(); cyc("R9");
    finishRun();
  end
endmodule